// File: doc/BRIEF.md
# Latched Error Status Word

This block is the read-only status and error word of a network interface. It takes single-cycle condition pulses from the surrounding logic and records each one in a sticky bit. The sources are the transmit queue, the interrupt queue, the physical-layer receiver, the message checker, the receive queue, the retry engine, the redundant-link selector and a general-purpose counter. A sticky bit stays set until the host reads the word. One bit of the word is a live copy of the transmit queue occupancy, and the remaining spare bits are tied to zero.

The host sees the word on `status_word` at all times. Asserting `host_rd` for one cycle marks a read. The word returned in that cycle is the value before clearing, and the clock edge that ends the cycle clears every sticky bit. An event that arrives in the same cycle as a clearing read is not lost: the bit is set again after the edge. An interrupt line is raised while any sticky bit is set together with its matching bit of `irq_enable`.

Top module: `err_status_word`

## Requirements
- R1: While `host_rd` is high, `status_word` shows the value from before the clear. At the rising edge that ends that cycle, sticky bits 0, 2, 4, 5, 6, 7, 8, 9, 10, 11, 12 and 13 are all cleared.
- R2: Bit 1 follows `txq_not_empty` in the same cycle. It is never latched and a read does not change it.
- R3: Bits 3, 14 and 15 of `status_word` always read 0.
- R4: A pulse on `txq_full` sets bit 0, and a pulse on `txq_high_water` (more than 7/8 full) sets bit 2.
- R5: Bit 5 is set by a pulse on any one of `phy_no_edge`, `phy_parity_err` or `phy_frame_err`.
- R6: Bits 6 to 11 are set by pulses on `carrier_loss`, `bad_msg`, `rxq_overflow`, `retry_bit_err`, `retry_timeout` and `link_failover`, in that order.
- R7: A pulse on `intq_full` sets bit 4, and a pulse on `gp_ctr_wrap` sets bit 12. Bit 13 is sticky but has no event source, so it stays 0.
- R8: When an event pulse coincides with a clearing read, the read returns the old value and the event's bit reads 1 after the edge.
- R9: Without a read, a set sticky bit stays set whatever the event inputs do.
- R10: When `rst` is high at a rising edge, all sticky bits clear, even if events arrive in that cycle.
- R11: `irq` is 1 in the same cycle exactly when some sticky bit and the same bit of `irq_enable` are both 1. Bit 1 and the constant-zero bits never raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_rd | input | 1 | Host read strobe; clears sticky bits at the clock edge |
| txq_not_empty | input | 1 | Live level: transmit queue holds a message |
| txq_full | input | 1 | Pulse: transmit queue full |
| txq_high_water | input | 1 | Pulse: transmit queue above 7/8 |
| intq_full | input | 1 | Pulse: interrupt queue full |
| phy_no_edge | input | 1 | Pulse: no transition for two clock periods |
| phy_parity_err | input | 1 | Pulse: line parity error |
| phy_frame_err | input | 1 | Pulse: line framing error |
| carrier_loss | input | 1 | Pulse: receiver lost carrier |
| bad_msg | input | 1 | Pulse: received message failed checks |
| rxq_overflow | input | 1 | Pulse: receive queue overflow |
| retry_bit_err | input | 1 | Pulse: retransmit after returned bit errors |
| retry_timeout | input | 1 | Pulse: retransmit after return timeout |
| link_failover | input | 1 | Pulse: redundant transceiver switched link |
| gp_ctr_wrap | input | 1 | Pulse: 16-bit general counter overflowed |
| irq_enable | input | 16 | Per-bit interrupt enable |
| status_word | output | 16 | Status word seen by the host |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives every event source on its own. For each one it checks that exactly the expected bit rises, that a read returns it and then clears it, and that the interrupt follows both a single-bit enable and its complement. A design with a wrong bit map, or one that ORs only some of the three physical-layer causes, shows a wrong word in this sweep. The bench fires each event in the same cycle as a read. A design that gives the clear priority loses the bit there, and one that updates the word before the read edge returns the wrong old value. The bench also asserts reset while events are present, holds sticky bits across many idle cycles, and toggles the live queue flag during reads. This catches a reset that loses to events, a bit that decays, and a live bit that is latched or cleared by a read.

// File: rtl/err_status_pkg.sv
package err_status_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned B_TXFULL  = 0;
  localparam int unsigned B_LIVE    = 1;
  localparam int unsigned B_TXHW    = 2;
  localparam int unsigned B_INTQ    = 4;
  localparam int unsigned B_PHY     = 5;
  localparam int unsigned B_CARRIER = 6;
  localparam int unsigned B_BADMSG  = 7;
  localparam int unsigned B_RXOV    = 8;
  localparam int unsigned B_RTBIT   = 9;
  localparam int unsigned B_RTTO    = 10;
  localparam int unsigned B_FAILOV  = 11;
  localparam int unsigned B_CTR     = 12;

  localparam logic [WORD_W-1:0] STICKY_MASK = 16'h3FF5;

  typedef logic [WORD_W-1:0] word_t;

  // next value of one sticky bit: reset, then set, then clear
  function automatic logic sticky_next(input logic q, input logic rst,
                                       input logic set, input logic clr);
    if (rst)      return 1'b0;
    else if (set) return 1'b1;
    else if (clr) return 1'b0;
    else          return q;
  endfunction

  // host-visible word from latched bits and the live flag
  function automatic word_t compose_word(input word_t sticky,
                                         input logic live);
    word_t w;
    w = sticky & STICKY_MASK;
    w[B_LIVE] = live;
    return w;
  endfunction
endpackage

// File: rtl/err_event_map.sv
module err_event_map
  import err_status_pkg::*;
(
  input  logic  txq_full,
  input  logic  txq_high_water,
  input  logic  intq_full,
  input  logic  phy_no_edge,
  input  logic  phy_parity_err,
  input  logic  phy_frame_err,
  input  logic  carrier_loss,
  input  logic  bad_msg,
  input  logic  rxq_overflow,
  input  logic  retry_bit_err,
  input  logic  retry_timeout,
  input  logic  link_failover,
  input  logic  gp_ctr_wrap,
  output word_t ev_vec
);
  always_comb begin
    ev_vec            = '0;
    ev_vec[B_TXFULL]  = txq_full;
    ev_vec[B_TXHW]    = txq_high_water;
    ev_vec[B_INTQ]    = intq_full;
    ev_vec[B_PHY]     = phy_no_edge | phy_parity_err | phy_frame_err;
    ev_vec[B_CARRIER] = carrier_loss;
    ev_vec[B_BADMSG]  = bad_msg;
    ev_vec[B_RXOV]    = rxq_overflow;
    ev_vec[B_RTBIT]   = retry_bit_err;
    ev_vec[B_RTTO]    = retry_timeout;
    ev_vec[B_FAILOV]  = link_failover;
    ev_vec[B_CTR]     = gp_ctr_wrap;
  end
endmodule

// File: rtl/err_sticky_bank.sv
module err_sticky_bank #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] q_vec
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_sticky
      logic q;
      always_ff @(posedge clk)
        q <= err_status_pkg::sticky_next(q, rst, set_vec[i], clr);
      assign q_vec[i] = q;
    end else begin : g_const
      assign q_vec[i] = 1'b0;
    end
  end
endmodule

// File: rtl/err_status_word.sv
module err_status_word
  import err_status_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        host_rd,
  input  logic        txq_not_empty,
  input  logic        txq_full,
  input  logic        txq_high_water,
  input  logic        intq_full,
  input  logic        phy_no_edge,
  input  logic        phy_parity_err,
  input  logic        phy_frame_err,
  input  logic        carrier_loss,
  input  logic        bad_msg,
  input  logic        rxq_overflow,
  input  logic        retry_bit_err,
  input  logic        retry_timeout,
  input  logic        link_failover,
  input  logic        gp_ctr_wrap,
  input  logic [15:0] irq_enable,
  output logic [15:0] status_word,
  output logic        irq
);
  word_t ev_vec;    // per-bit set requests after merging sources
  word_t sticky_q;  // latched bits only
  logic  clr_now;   // read clears at the edge ending this cycle

  assign clr_now = host_rd;

  err_event_map u_map (
    .txq_full(txq_full), .txq_high_water(txq_high_water),
    .intq_full(intq_full), .phy_no_edge(phy_no_edge),
    .phy_parity_err(phy_parity_err), .phy_frame_err(phy_frame_err),
    .carrier_loss(carrier_loss), .bad_msg(bad_msg),
    .rxq_overflow(rxq_overflow), .retry_bit_err(retry_bit_err),
    .retry_timeout(retry_timeout), .link_failover(link_failover),
    .gp_ctr_wrap(gp_ctr_wrap), .ev_vec(ev_vec)
  );

  err_sticky_bank #(.W(WORD_W), .MASK(STICKY_MASK)) u_bank (
    .clk(clk), .rst(rst), .clr(clr_now),
    .set_vec(ev_vec), .q_vec(sticky_q)
  );

  assign status_word = compose_word(sticky_q, txq_not_empty);
  assign irq         = |(sticky_q & irq_enable);
endmodule

// File: rtl/err_status_chk.sv
module err_status_chk #(
  parameter logic [15:0] MASK = 16'h3FF5
) (
  input logic        clk,
  input logic        rst,
  input logic        host_rd,
  input logic        txq_not_empty,
  input logic [15:0] ev_vec,
  input logic [15:0] status_word,
  input logic [15:0] irq_enable,
  input logic        irq
);
  // R1
  a_r1_read_clears: assert property (@(posedge clk) disable iff (rst)
    (host_rd && ((ev_vec & MASK) == 16'h0)) |=> ((status_word & MASK) == 16'h0));
  // R8
  a_r8_event_kept: assert property (@(posedge clk) disable iff (rst)
    ((ev_vec & MASK) != 16'h0) |=>
      ((status_word & $past(ev_vec & MASK)) == $past(ev_vec & MASK)));
  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> ((status_word & $past(status_word) & MASK) ==
                  ($past(status_word) & MASK)));
  // R2
  a_r2_live_bit: assert property (@(posedge clk) disable iff (rst)
    status_word[1] == txq_not_empty);
  // R3
  a_r3_zero_bits: assert property (@(posedge clk) disable iff (rst)
    (status_word[3] == 1'b0) && (status_word[15:14] == 2'b00));
  // R11
  a_r11_irq: assert property (@(posedge clk) disable iff (rst)
    irq == (|(status_word & irq_enable & MASK)));
endmodule

bind err_status_word err_status_chk #(.MASK(err_status_pkg::STICKY_MASK)) u_chk (
  .clk(clk), .rst(rst), .host_rd(host_rd), .txq_not_empty(txq_not_empty),
  .ev_vec(ev_vec), .status_word(status_word), .irq_enable(irq_enable),
  .irq(irq)
);

// File: tb/sim_err_status_word.sv
module sim_err_status_word;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] STICKY = 16'b0011_1111_1111_0101;

  logic clk = 1'b0, rst = 1'b1, host_rd = 1'b0, live = 1'b0;
  logic [12:0] ev = '0;
  logic [15:0] ien = '0;
  logic [15:0] word;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_status_word u0 (
    .clk(clk), .rst(rst), .host_rd(host_rd), .txq_not_empty(live),
    .txq_full(ev[0]), .txq_high_water(ev[1]), .intq_full(ev[2]),
    .phy_no_edge(ev[3]), .phy_parity_err(ev[4]), .phy_frame_err(ev[5]),
    .carrier_loss(ev[6]), .bad_msg(ev[7]), .rxq_overflow(ev[8]),
    .retry_bit_err(ev[9]), .retry_timeout(ev[10]), .link_failover(ev[11]),
    .gp_ctr_wrap(ev[12]), .irq_enable(ien), .status_word(word), .irq(irq)
  );

  // source index -> status bit, restated arithmetically
  function automatic int bit_of(int k);
    if (k < 3) return 2 * k;
    if (k < 6) return 5;
    return k;
  endfunction

  function automatic string req_of(int k);
    if (k == 0 || k == 1) return "R4";
    if (k == 2 || k == 12) return "R7";
    if (k < 6) return "R5";
    return "R6";
  endfunction

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // move to mid-low phase of the next cycle
  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ev = '1;
    step(); step();
    rst = 1'b0; ev = '0;
    #1 chk("R10 reset state", word, 16'h0000);
    chk("R11 reset irq", {15'b0, irq}, 16'h0);

    // sweep every source
    for (int k = 0; k < 13; k++) begin
      logic [15:0] e;
      e = 16'h1 << bit_of(k);
      ev[k] = 1'b1; step(); ev[k] = 1'b0;
      #1 chk(req_of(k), word, e);
      ien = e; #1 chk("R11 irq on", {15'b0, irq}, 16'h1);
      ien = ~e; #1 chk("R11 irq off", {15'b0, irq}, 16'h0);
      ien = '0;
      for (int j = 0; j < 5; j++) step();
      #1 chk("R9 hold", word, e);
      host_rd = 1'b1; #1 chk("R1 old value on read", word, e);
      step(); host_rd = 1'b0;
      #1 chk("R1 cleared", word, 16'h0000);
    end

    // all sources, then collision with read
    ev = '1; step(); ev = '0;
    #1 chk("R7 bit13 stays 0 / all set", word, STICKY & ~16'h2000);
    ien = 16'hC00A; #1 chk("R11 non-sticky enables", {15'b0, irq}, 16'h0);
    ien = '0;
    for (int k = 0; k < 13; k++) begin
      host_rd = 1'b1; ev[k] = 1'b1;
      #1 chk("R8 read sees old", word, (k == 0) ? (STICKY & ~16'h2000) : (16'h1 << bit_of(k-1)));
      step(); host_rd = 1'b0; ev[k] = 1'b0;
      #1 chk("R8 event kept", word, 16'h1 << bit_of(k));
    end
    host_rd = 1'b1; step(); host_rd = 1'b0;

    // live bit
    live = 1'b1; #1 chk("R2 live on", word, 16'h0002);
    ien = 16'h0002; #1 chk("R11 live bit no irq", {15'b0, irq}, 16'h0);
    ien = '0;
    host_rd = 1'b1; step(); host_rd = 1'b0;
    #1 chk("R2 live kept after read", word, 16'h0002);
    live = 1'b0; #1 chk("R2 live off", word, 16'h0000);
    chk("R3 zero bits", word & 16'hC008, 16'h0);

    // reset beats events
    ev = '1; rst = 1'b1; step(); rst = 1'b0; ev = '0;
    #1 chk("R10 reset wins", word, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule